// File: doc/BRIEF.md
# Double-Data-Rate Write Data Receiver

This block sits on the receive side of a 16-bit double-data-rate write path. The bus is split into byte lanes, and each lane has its own source-synchronous strobe and its own mask pin. Each lane takes a data byte and a mask bit on the rising edge of its strobe, and takes a second data byte and mask bit on the falling edge. The two halves of a strobe cycle become one lane entry. Each lane writes its entries into a small gray-pointer queue. The core clock domain reads that queue.

On the core side, one entry from every lane is combined into a single word that is twice the pin width. Rising-edge bytes fill the low half of the word and falling-edge bytes fill the high half. Every captured mask bit becomes an active-high byte enable. Write commands arrive on the core clock and are sampled on its rising edge. Each command carries a burst-length code, which tells the block how many words make up that burst, so the block can flag the final word. Finished words go into a two-entry holding stage that drives a valid/ready stream.

Back-pressure rules for the stream are as follows. When `m_valid` is high and `m_ready` is low, the word, its enables and its last flag stay frozen until the consumer accepts them. A transfer takes place on every rising clock edge where both signals are high. The strobe side cannot be stalled. The consumer must therefore drain the stream quickly enough that a lane queue never holds more than its depth.

Top module: `wcap_ddr_write_rx`

## Requirements
- R1: The byte on lane i at the rising edge of that lane's strobe appears in `m_data[8*i +: 8]`.
- R2: The byte on lane i at the falling edge of that lane's strobe appears in `m_data[16 + 8*i +: 8]`.
- R3: `m_be[i]` is the inverse of lane i's mask at the rising edge, and `m_be[2 + i]` is the inverse of that mask at the falling edge. A masked byte still carries its data.
- R4: The lanes capture independently of one another. A word is correct whichever lane's strobe edges arrive first.
- R5: Command code `cmd_bl` = 1, 2 or 3 means a burst of 1, 2 or 4 words (burst length 2, 4 or 8), and code 0 counts as 1 word. `m_last` is high on exactly the final word of each burst.
- R6: A captured word is held back from the output until a write command is pending to account for it.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid` stays high on the next cycle and `m_data`, `m_be` and `m_last` stay unchanged.
- R8: Every captured word is delivered exactly once, in capture order, and no other word is delivered.
- R9: While `rst_n` is low, `m_valid` is low, and every queued word and command is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| cmd_valid | input | 1 | Write command, sampled on the rising edge of clk |
| cmd_bl | input | 2 | Burst-length code that goes with the command |
| wr_dqs | input | 2 | One write strobe for each byte lane |
| wr_dq | input | 16 | Write data pins |
| wr_dm | input | 2 | Mask pins, one for each lane, active high |
| m_valid | output | 1 | Output word is valid |
| m_ready | input | 1 | Consumer can accept the word |
| m_data | output | 32 | Combined word, with rising-edge bytes in the low half |
| m_be | output | 4 | Byte enables, active high |
| m_last | output | 1 | Final word of the burst |

## Verification
The assertions depend on three things about the inputs. Commands never arrive while the command queue is full. Each lane's strobe toggles cleanly, with data settled on either side of each edge. No burst pushes a lane queue past its depth. The stimulus respects these by holding each new burst back until the model's outstanding word count leaves room in the queue. It drives data half an edge-gap ahead of each strobe transition and waits for each burst to finish before it issues the next command. Within these limits, the stimulus still moves the lane skew in both directions, sends data before its command, and stalls the consumer.

// File: rtl/wcap_pkg.sv
`timescale 1ns/1ps
package wcap_pkg;

  typedef enum logic [1:0] {
    BLC_DEFAULT = 2'd0,
    BLC_2       = 2'd1,
    BLC_4       = 2'd2,
    BLC_8       = 2'd3
  } blc_e;

  // Number of core words in one burst for a given code.
  function automatic int unsigned words_for_code(input logic [1:0] code);
    case (blc_e'(code))
      BLC_4:   return 2;
      BLC_8:   return 4;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/wcap_lane_rx.sv
`timescale 1ns/1ps
module wcap_lane_rx #(
  parameter int LANE_W = 8,
  parameter int AW     = 2,
  parameter int SYNC   = 2
) (
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [LANE_W-1:0] pin_d,
  input  logic              pin_m,
  input  logic              clk,
  input  logic              pop,
  output logic              empty,
  output logic [LANE_W-1:0] rise_d,
  output logic [LANE_W-1:0] fall_d,
  output logic              rise_m,
  output logic              fall_m
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam int EW    = 2 * LANE_W + 2;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // Rising-edge half of the entry
  logic [LANE_W-1:0] cap_d;
  logic              cap_m;
  always_ff @(posedge strobe or negedge rst_n) begin
    if (!rst_n) begin
      cap_d <= '0;
      cap_m <= 1'b1;
    end else begin
      cap_d <= pin_d;
      cap_m <= pin_m;
    end
  end

  // Falling edge completes the entry and advances the write pointer
  logic [EW-1:0] ram [DEPTH];
  logic [PW-1:0] wbin, wgray, wbin_nx;
  assign wbin_nx = wbin + 1'b1;

  always_ff @(negedge strobe or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= to_gray(wbin_nx);
    end
  end

  always_ff @(negedge strobe) begin
    ram[wbin[AW-1:0]] <= {pin_m, pin_d, cap_m, cap_d};
  end

  // Write pointer into the core domain
  logic [PW-1:0] sync_q [SYNC];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= wgray;
      for (int i = 1; i < SYNC; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  // Read side
  logic [PW-1:0] rbin, rgray, rbin_nx;
  assign rbin_nx = rbin + 1'b1;
  assign empty   = (rgray == sync_q[SYNC-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (pop && !empty) begin
      rbin  <= rbin_nx;
      rgray <= to_gray(rbin_nx);
    end
  end

  assign {fall_m, fall_d, rise_m, rise_d} = ram[rbin[AW-1:0]];

endmodule

// File: rtl/wcap_burst_track.sv
`timescale 1ns/1ps
module wcap_burst_track
  import wcap_pkg::*;
#(
  parameter int CMD_AW    = 2,
  parameter int MAX_WORDS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_bl,
  input  logic       advance,
  output logic       has_cmd,
  output logic       is_last,
  output logic       full
);
  localparam int CMD_D = 1 << CMD_AW;
  localparam int CW    = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

  logic [1:0]      cq [CMD_D];
  logic [CMD_AW:0] wp, rp, fill;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   last_idx;
  int unsigned     words;

  assign fill    = wp - rp;
  assign full    = (fill == CMD_D[CMD_AW:0]);
  assign has_cmd = (fill != '0);

  always_comb begin
    words = words_for_code(cq[rp[CMD_AW-1:0]]);
    if (words > MAX_WORDS) words = MAX_WORDS;
    last_idx = CW'(words - 1);
  end

  assign is_last = (cnt == last_idx);

  always_ff @(posedge clk) begin
    if (cmd_valid && !full) cq[wp[CMD_AW-1:0]] <= cmd_bl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (cmd_valid && !full) wp <= wp + 1'b1;
      if (advance && has_cmd) begin
        if (is_last) begin
          cnt <= '0;
          rp  <= rp + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/wcap_hold2.sv
`timescale 1ns/1ps
module wcap_hold2 #(
  parameter int W = 37
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic [W-1:0] ent [2];
  logic         wsel, rsel;
  logic [1:0]   cnt;
  logic         push, pull;

  assign in_ready  = (cnt != 2'd2);
  assign out_valid = (cnt != 2'd0);
  assign out_data  = ent[rsel];
  assign push      = in_valid && in_ready;
  assign pull      = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push) ent[wsel] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel <= 1'b0;
      rsel <= 1'b0;
      cnt  <= 2'd0;
    end else begin
      if (push) wsel <= ~wsel;
      if (pull) rsel <= ~rsel;
      case ({push, pull})
        2'b10:   cnt <= cnt + 2'd1;
        2'b01:   cnt <= cnt - 2'd1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/wcap_ddr_write_rx.sv
`timescale 1ns/1ps
module wcap_ddr_write_rx #(
  parameter int LANE_W      = 8,
  parameter int LANES       = 2,
  parameter int FIFO_AW     = 2,
  parameter int SYNC_STAGES = 2,
  parameter int CMD_AW      = 2,
  parameter int MAX_WORDS   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic [1:0]                  cmd_bl,
  input  logic [LANES-1:0]            wr_dqs,
  input  logic [LANES*LANE_W-1:0]     wr_dq,
  input  logic [LANES-1:0]            wr_dm,
  output logic                        m_valid,
  input  logic                        m_ready,
  output logic [2*LANES*LANE_W-1:0]   m_data,
  output logic [2*LANES-1:0]          m_be,
  output logic                        m_last
);
  localparam int DQ_W   = LANES * LANE_W;
  localparam int WORD_W = 2 * DQ_W;
  localparam int BE_W   = 2 * LANES;
  localparam int PAY_W  = WORD_W + BE_W + 1;

  logic [LANES-1:0]  lane_empty;
  logic [LANES-1:0]  lane_rm, lane_fm;
  logic [LANE_W-1:0] lane_rd [LANES];
  logic [LANE_W-1:0] lane_fd [LANES];

  logic has_cmd, is_last, cmd_full;
  logic buf_ready, advance;
  logic [WORD_W-1:0] word;
  logic [BE_W-1:0]   be;
  logic [PAY_W-1:0]  out_pay;

  assign advance = ~|lane_empty && has_cmd && buf_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wcap_lane_rx #(
      .LANE_W (LANE_W),
      .AW     (FIFO_AW),
      .SYNC   (SYNC_STAGES)
    ) u_lane (
      .rst_n  (rst_n),
      .strobe (wr_dqs[g]),
      .pin_d  (wr_dq[g*LANE_W +: LANE_W]),
      .pin_m  (wr_dm[g]),
      .clk    (clk),
      .pop    (advance),
      .empty  (lane_empty[g]),
      .rise_d (lane_rd[g]),
      .fall_d (lane_fd[g]),
      .rise_m (lane_rm[g]),
      .fall_m (lane_fm[g])
    );
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      word[i*LANE_W +: LANE_W]        = lane_rd[i];
      word[DQ_W + i*LANE_W +: LANE_W] = lane_fd[i];
      be[i]                           = ~lane_rm[i];
      be[LANES + i]                   = ~lane_fm[i];
    end
  end

  wcap_burst_track #(
    .CMD_AW    (CMD_AW),
    .MAX_WORDS (MAX_WORDS)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_bl    (cmd_bl),
    .advance   (advance),
    .has_cmd   (has_cmd),
    .is_last   (is_last),
    .full      (cmd_full)
  );

  wcap_hold2 #(.W(PAY_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (~|lane_empty && has_cmd),
    .in_ready  (buf_ready),
    .in_data   ({is_last, be, word}),
    .out_valid (m_valid),
    .out_ready (m_ready),
    .out_data  (out_pay)
  );

  assign {m_last, m_be, m_data} = out_pay;

endmodule

// File: rtl/wcap_ddr_write_rx_chk.sv
`timescale 1ns/1ps
module wcap_ddr_write_rx_chk #(
  parameter int WORD_W    = 32,
  parameter int BE_W      = 4,
  parameter int MAX_WORDS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m_valid,
  input logic              m_ready,
  input logic [WORD_W-1:0] m_data,
  input logic [BE_W-1:0]   m_be,
  input logic              m_last,
  input logic              cmd_valid,
  input logic              cmd_full
);
  int unsigned beat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_cnt <= 0;
    else if (m_valid && m_ready) beat_cnt <= m_last ? 0 : beat_cnt + 1;
  end

  always @(posedge clk) begin
    if (!rst_n) AST_RESET_IDLE: assert (!m_valid); // R9
  end

  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid); // R7

  AST_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> $stable(m_data) && $stable(m_be) && $stable(m_last)); // R7

  AST_CMD_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !cmd_full); // R5

  AST_BURST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready |-> beat_cnt < MAX_WORDS); // R5

  AST_BURST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && (beat_cnt == MAX_WORDS - 1) |-> m_last); // R5

endmodule

bind wcap_ddr_write_rx wcap_ddr_write_rx_chk #(
  .WORD_W    (WORD_W),
  .BE_W      (BE_W),
  .MAX_WORDS (MAX_WORDS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .m_data    (m_data),
  .m_be      (m_be),
  .m_last    (m_last),
  .cmd_valid (cmd_valid),
  .cmd_full  (cmd_full)
);

// File: tb/test_wcap_ddr_write_rx.sv
`timescale 1ns/1ps
module test_wcap_ddr_write_rx;

  typedef struct packed {
    logic [31:0] data;
    logic [3:0]  be;
    logic        last;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_bl = 2'd0;
  logic [1:0]  wr_dqs = 2'b00;
  logic [15:0] wr_dq = '0;
  logic [1:0]  wr_dm = 2'b00;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [31:0] m_data;
  logic [3:0]  m_be;
  logic        m_last;

  int errors = 0;
  int checks = 0;
  exp_t exp_q[$];
  int  ready_mode = 0;   // 0 always ready, 1 pattern, 2 never
  int  cyc = 0;
  logic       prev_stall = 1'b0;
  logic [36:0] prev_pay = '0;
  logic       mon_on = 1'b0;

  always #2 clk = ~clk;

  wcap_ddr_write_rx i_wcap_ddr_write_rx (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_bl(cmd_bl),
    .wr_dqs(wr_dqs), .wr_dq(wr_dq), .wr_dm(wr_dm),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_be(m_be), .m_last(m_last)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Per-clock reference comparison, 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    if (mon_on) begin
      if (prev_stall) begin
        check(m_valid === 1'b1, "R7 valid held", {63'd0, m_valid}, 64'd1);
        check({m_last, m_be, m_data} === prev_pay, "R7 payload held",
              {27'd0, m_last, m_be, m_data}, {27'd0, prev_pay});
      end
      case (ready_mode)
        0: m_ready = 1'b1;
        1: m_ready = ((cyc % 5) < 2);
        default: m_ready = 1'b0;
      endcase
      if (m_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected word", {32'd0, m_data}, 64'd0);
        end else if (m_ready) begin
          exp_t e;
          e = exp_q.pop_front();
          check(m_data[15:0] === e.data[15:0], "R1 rise bytes", {48'd0, m_data[15:0]}, {48'd0, e.data[15:0]});
          check(m_data[31:16] === e.data[31:16], "R2 fall bytes", {48'd0, m_data[31:16]}, {48'd0, e.data[31:16]});
          check(m_be === e.be, "R3 byte enables", {60'd0, m_be}, {60'd0, e.be});
          check(m_last === e.last, "R5 last flag", {63'd0, m_last}, {63'd0, e.last});
        end
      end
      prev_stall = m_valid && !m_ready;
      prev_pay   = {m_last, m_be, m_data};
    end
  end

  task automatic issue_cmd(input logic [1:0] code);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_bl    = code;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Drives one burst on both lanes; skew_dir=1 lets lane 1 lead (R4)
  task automatic drive_words(input int n, input bit skew_dir);
    int a, b;
    a = skew_dir ? 1 : 0;
    b = 1 - a;
    for (int k = 0; k < n; k++) begin
      logic [15:0] rd, fd;
      logic [1:0]  rm, fm;
      exp_t e;
      rd = 16'($urandom); fd = 16'($urandom);
      rm = 2'($urandom);  fm = 2'($urandom);
      e.data = {fd, rd};
      e.be   = ~{fm, rm};
      e.last = (k == n - 1);
      exp_q.push_back(e);
      wr_dq = rd; wr_dm = rm;
      #0.5 wr_dqs[a] = 1'b1;
      #0.5 wr_dqs[b] = 1'b1;
      #0.5 wr_dq = fd; wr_dm = fm;
      #0.5 wr_dqs[a] = 1'b0;
      #0.5 wr_dqs[b] = 1'b0;
      #0.5;
    end
  endtask

  task automatic wait_room(input int n);
    while (exp_q.size() + n > 4) @(posedge clk);
  endtask

  task automatic wait_drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 2000) begin
      @(posedge clk);
      t++;
    end
    check(exp_q.size() == 0, "R8 all words delivered", 64'(exp_q.size()), 64'd0);
  endtask

  function automatic int words_of(input logic [1:0] code);
    return (code == 2'd2) ? 2 : (code == 2'd3) ? 4 : 1;
  endfunction

  task automatic burst(input logic [1:0] code, input bit skew_dir);
    int n = words_of(code);
    wait_room(n);
    issue_cmd(code);
    drive_words(n, skew_dir);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(m_valid === 1'b0, "R9 reset idle", {63'd0, m_valid}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (3) @(posedge clk);

    // All codes, both skews, consumer always ready
    for (int c = 0; c < 4; c++) begin
      burst(2'(c), 1'b0);
      wait_drain();
      burst(2'(c), 1'b1);
      wait_drain();
    end

    // Back-to-back bursts with a stalling consumer
    ready_mode = 1;
    for (int r = 0; r < 12; r++) begin
      burst(2'(r % 4), r[0]);
    end
    wait_drain();

    // Data ahead of its command must wait (R6)
    ready_mode = 0;
    drive_words(2, 1'b0);
    repeat (10) @(posedge clk);
    #1.5;
    check(m_valid === 1'b0, "R6 held without command", {63'd0, m_valid}, 64'd0);
    issue_cmd(2'd2);
    wait_drain();

    // Stall then reset: pending words discarded (R9)
    ready_mode = 2;
    burst(2'd3, 1'b1);
    repeat (12) @(posedge clk);
    #1.5;
    check(m_valid === 1'b1, "R7 word waiting under stall", {63'd0, m_valid}, 64'd1);
    mon_on = 1'b0;
    prev_stall = 1'b0;
    rst_n = 1'b0;
    #1;
    check(m_valid === 1'b0, "R9 reset clears output", {63'd0, m_valid}, 64'd0);
    exp_q.delete();
    @(negedge clk);
    rst_n = 1'b1;
    ready_mode = 0;
    repeat (6) @(posedge clk);
    #1.5;
    check(m_valid === 1'b0, "R9 nothing left after reset", {63'd0, m_valid}, 64'd0);
    mon_on = 1'b1;

    // Traffic resumes cleanly after reset
    burst(2'd3, 1'b0);
    burst(2'd1, 1'b1);
    wait_drain();
    repeat (10) @(posedge clk);
    #1.5;
    check(m_valid === 1'b0, "R8 no extra word", {63'd0, m_valid}, 64'd0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

endmodule